// File: doc/BRIEF.md
# Spread-Spectrum Triangle Profile Generator

This block produces the slow frequency-deviation waveform that a fractional-N feedback divider follows so that a clock synthesizer spreads its output energy over a band and lowers peak emissions. It runs from the reference-rate clock. A 2-bit spread selector picks one of three modes: a profile that only lowers the frequency, a profile that swings evenly above and below nominal, or no spreading.

On every reference cycle the block presents two words. The first is the signed deviation, in units of 1/65536 of the nominal divide ratio. The second is the effective divide value: 80 plus that deviation, as an unsigned number with 16 fraction bits. The profile is a symmetric linear triangle whose period is 832 reference cycles by default, which gives about 30 kHz from a 25 MHz reference. A mode change is held off until the running profile sits at a point of zero deviation, so the divide value never steps.

Top module: `ssc_profile_gen`

## Requirements
- R1: While reset is sampled low, the deviation is 0 and the divide word is 5242880 (80.0) from the first clock edge of reset on.
- R2: Selector code 11 means no spreading: while that mode is active the deviation stays 0 on every cycle.
- R3: Selector codes 01 and 10 both select the centred profile and give identical cycle-by-cycle output.
- R4: Code 00 selects down-spread: at phase p (0..831) the deviation is -floor(m*328/416), where m = p for p < 416 and 832-p otherwise. It starts at phase 0 (zero deviation) and is never positive.
- R5: In centred mode the deviation at phase p is trunc(s*164/208) toward zero, where s = p for p < 208, 416-p for p < 624, and p-832 otherwise. The profile starts at zero and rises first.
- R6: The phase advances by one per cycle and wraps from 831 to 0, so the profile repeats every 832 cycles.
- R7: The divide word equals 80*65536 + 80*deviation on every cycle.
- R8: A new mode takes effect only on a cycle whose phase is a zero point of the active profile (phase 0 for down-spread; phase 0 or 416 for centred; any cycle when spreading is off). On that cycle the new mode begins at phase 0.
- R9: Successive deviation values never differ by more than one unit.
- R10: Down-spread deviation stays within [-328, 0] and centred deviation within [-164, 164].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference-rate clock |
| rst_n_i | input | 1 | Synchronous active-low reset |
| spread_sel_i | input | 2 | Spread mode: 00 down, 01/10 centred, 11 off |
| dev_o | output | 16 | Signed deviation, 1/65536 of nominal ratio |
| div_o | output | 23 | Effective divide value, unsigned, 16 fraction bits |

## Verification
The mode-change gate and the phase wrap can land on the same cycle: a request that arrives just as the phase returns to 0 or reaches the centred mid-point must switch mode and restart the phase together, with no output step. The bench steps the running profile until its own phase count sits exactly on such a point, then changes the selector on that cycle. It also changes the selector mid-ramp, where the change must wait. Every cycle is judged against a phase and mode model kept in the bench, together with the step-size and range limits.

// File: rtl/ssc_pkg.sv
// Shared types for the spread profile generator.
// Assumes a 2-bit spread selector with the code meaning fixed at the pins.
package ssc_pkg;

    typedef enum logic [1:0] {
        SPR_OFF    = 2'd0,
        SPR_DOWN   = 2'd1,
        SPR_CENTER = 2'd2
    } spr_mode_e;

    // Map the selector pin code onto an internal mode.
    function automatic spr_mode_e decode_sel(input logic [1:0] sel);
        case (sel)
            2'b00:   return SPR_DOWN;
            2'b11:   return SPR_OFF;
            default: return SPR_CENTER;
        endcase
    endfunction

endpackage

// File: rtl/ssc_phase_ctr.sv
// Triangle phase counter: counts 0..PERIOD-1 and wraps.
// Assumes restart and run come from the mode controller; held at 0 when not running.
module ssc_phase_ctr #(
    parameter int PERIOD = 832,
    localparam int PH_W  = $clog2(PERIOD)
) (
    input  logic            clk_i,
    input  logic            rst_n_i,
    input  logic            restart_i,
    input  logic            run_i,
    output logic [PH_W-1:0] ph_o
);

    // Advance the phase by one each cycle, clearing on reset, restart or idle.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i || restart_i || !run_i) begin
            ph_o <= '0;
        end else if (ph_o == PH_W'(PERIOD - 1)) begin
            ph_o <= '0;
        end else begin
            ph_o <= ph_o + 1'b1;
        end
    end

endmodule

// File: rtl/ssc_mode_ctrl.sv
// Mode controller: holds the active spread mode and admits a requested
// change only at a zero-deviation point of the running profile.
// Assumes the phase input is the registered counter value.
module ssc_mode_ctrl
    import ssc_pkg::*;
#(
    parameter int HALF_STEPS = 416,
    localparam int PERIOD    = 2 * HALF_STEPS,
    localparam int PH_W      = $clog2(PERIOD)
) (
    input  logic            clk_i,
    input  logic            rst_n_i,
    input  logic [1:0]      sel_i,
    input  logic [PH_W-1:0] ph_i,
    output spr_mode_e       act_o,
    output logic            restart_o
);

    spr_mode_e req;
    logic      at_zero;

    // Find whether the current cycle is a zero point of the active profile.
    always_comb begin
        req     = decode_sel(sel_i);
        at_zero = (act_o == SPR_OFF) || (ph_i == '0) ||
                  ((act_o == SPR_CENTER) && (ph_i == PH_W'(HALF_STEPS)));
        restart_o = at_zero && (req != act_o);
    end

    // Latch the requested mode when the gate opens.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            act_o <= SPR_OFF;
        end else if (restart_o) begin
            act_o <= req;
        end
    end

endmodule

// File: rtl/ssc_shape.sv
// Profile shaper: maps phase and mode to a signed deviation.
// Assumes HALF_STEPS is even so the centred quarter points are integral.
module ssc_shape
    import ssc_pkg::*;
#(
    parameter int HALF_STEPS = 416,
    parameter int DOWN_PEAK  = 328,
    parameter int CTR_PEAK   = 164,
    parameter int DEV_W      = 16,
    localparam int PERIOD    = 2 * HALF_STEPS,
    localparam int QUARTER   = HALF_STEPS / 2,
    localparam int PH_W      = $clog2(PERIOD)
) (
    input  logic [PH_W-1:0]          ph_i,
    input  spr_mode_e                act_i,
    output logic signed [DEV_W-1:0]  dev_o
);

    int p;
    int fold;
    int s;
    int mag;

    // Build the folded ramp and scale it to the selected peak.
    always_comb begin
        p    = int'(ph_i);
        fold = (p < HALF_STEPS) ? p : (PERIOD - p);
        if (p < QUARTER) begin
            s = p;
        end else if (p < 3 * QUARTER) begin
            s = HALF_STEPS - p;
        end else begin
            s = p - PERIOD;
        end
        mag = 0;
        case (act_i)
            SPR_DOWN: begin
                mag = -((fold * DOWN_PEAK) / HALF_STEPS);
            end
            SPR_CENTER: begin
                if (s < 0) begin
                    mag = -(((-s) * CTR_PEAK) / QUARTER);
                end else begin
                    mag = (s * CTR_PEAK) / QUARTER;
                end
            end
            default: mag = 0;
        endcase
        dev_o = DEV_W'(mag);
    end

endmodule

// File: rtl/ssc_ratio.sv
// Ratio former: nominal divide value plus the scaled deviation, in
// unsigned fixed point. Assumes the deviation never drives the result negative.
module ssc_ratio #(
    parameter int NOM_RATIO = 80,
    parameter int FRAC_W    = 16,
    parameter int DEV_W     = 16,
    localparam int DIV_W    = $clog2(NOM_RATIO + 1) + FRAC_W
) (
    input  logic signed [DEV_W-1:0] dev_i,
    output logic [DIV_W-1:0]        div_o
);

    int sum;

    // Scale the deviation by the nominal ratio and add the nominal word.
    always_comb begin
        sum   = (NOM_RATIO << FRAC_W) + NOM_RATIO * int'(dev_i);
        div_o = DIV_W'(sum);
    end

endmodule

// File: rtl/ssc_profile_gen.sv
// Top level of the spread profile generator.
// Assumes clk_i is the synthesizer reference and that the consumer
// samples dev_o/div_o once per reference cycle.
module ssc_profile_gen
    import ssc_pkg::*;
#(
    parameter int HALF_STEPS = 416,
    parameter int DOWN_PEAK  = 328,
    parameter int CTR_PEAK   = 164,
    parameter int NOM_RATIO  = 80,
    parameter int FRAC_W     = 16,
    parameter int DEV_W      = 16,
    localparam int PERIOD    = 2 * HALF_STEPS,
    localparam int PH_W      = $clog2(PERIOD),
    localparam int DIV_W     = $clog2(NOM_RATIO + 1) + FRAC_W
) (
    input  logic                    clk_i,
    input  logic                    rst_n_i,
    input  logic [1:0]              spread_sel_i,
    output logic signed [DEV_W-1:0] dev_o,
    output logic [DIV_W-1:0]        div_o
);

    spr_mode_e       act_mode;
    logic            restart;
    logic            run;
    logic [PH_W-1:0] ph;

    // The phase only moves while a spreading mode is active.
    always_comb run = (act_mode != SPR_OFF);

    ssc_mode_ctrl #(.HALF_STEPS(HALF_STEPS)) u_mode (
        .clk_i     (clk_i),
        .rst_n_i   (rst_n_i),
        .sel_i     (spread_sel_i),
        .ph_i      (ph),
        .act_o     (act_mode),
        .restart_o (restart)
    );

    ssc_phase_ctr #(.PERIOD(PERIOD)) u_phase (
        .clk_i     (clk_i),
        .rst_n_i   (rst_n_i),
        .restart_i (restart),
        .run_i     (run),
        .ph_o      (ph)
    );

    ssc_shape #(
        .HALF_STEPS (HALF_STEPS),
        .DOWN_PEAK  (DOWN_PEAK),
        .CTR_PEAK   (CTR_PEAK),
        .DEV_W      (DEV_W)
    ) u_shape (
        .ph_i  (ph),
        .act_i (act_mode),
        .dev_o (dev_o)
    );

    ssc_ratio #(
        .NOM_RATIO (NOM_RATIO),
        .FRAC_W    (FRAC_W),
        .DEV_W     (DEV_W)
    ) u_ratio (
        .dev_i (dev_o),
        .div_o (div_o)
    );

endmodule

// File: rtl/ssc_profile_chk.sv
// Property checker for the spread profile generator, bound to the top.
module ssc_profile_chk
    import ssc_pkg::*;
#(
    parameter int HALF_STEPS = 416,
    parameter int DOWN_PEAK  = 328,
    parameter int CTR_PEAK   = 164,
    parameter int DEV_W      = 16,
    localparam int STEP_D    = (DOWN_PEAK + HALF_STEPS - 1) / HALF_STEPS,
    localparam int STEP_C    = (2 * CTR_PEAK + HALF_STEPS - 1) / HALF_STEPS,
    localparam int STEP_MAX  = (STEP_D > STEP_C) ? STEP_D : STEP_C
) (
    input  logic                    clk_i,
    input  logic                    rst_n_i,
    input  spr_mode_e               act_i,
    input  logic signed [DEV_W-1:0] dev_i
);

    logic live;

    // Mark cycles whose previous sample already follows a reset edge.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) live <= 1'b0;
        else          live <= 1'b1;
    end

    a_r1_reset_zero: assert property (@(posedge clk_i)
        !rst_n_i |=> (dev_i == '0));

    a_r2_off_zero: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        live && (act_i == SPR_OFF) |-> (dev_i == '0));

    a_r10_down_range: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        live && (act_i == SPR_DOWN) |-> (int'(dev_i) <= 0) && (int'(dev_i) >= -DOWN_PEAK));

    a_r10_ctr_range: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        live && (act_i == SPR_CENTER) |-> (int'(dev_i) <= CTR_PEAK) && (int'(dev_i) >= -CTR_PEAK));

    a_r9_no_jump: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        live |-> ((int'(dev_i) - int'($past(dev_i)) <= STEP_MAX) &&
                  (int'($past(dev_i)) - int'(dev_i) <= STEP_MAX)));

    a_r8_switch_at_zero: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        live && (act_i != $past(act_i)) |-> ($past(dev_i) == '0) && (dev_i == '0));

endmodule

bind ssc_profile_gen ssc_profile_chk #(
    .HALF_STEPS (HALF_STEPS),
    .DOWN_PEAK  (DOWN_PEAK),
    .CTR_PEAK   (CTR_PEAK),
    .DEV_W      (DEV_W)
) u_chk (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_i),
    .act_i   (act_mode),
    .dev_i   (dev_o)
);

// File: tb/ssc_profile_gen_tb.sv
module ssc_profile_gen_tb;

    localparam int HALF = 416;
    localparam int PER  = 832;
    localparam int Q    = 208;
    localparam int DPK  = 328;
    localparam int CPK  = 164;
    localparam int NOM  = 80;
    localparam int NOMW = NOM * 65536;

    logic               clk = 1'b0;
    logic               rst_n;
    logic [1:0]         sel;
    logic signed [15:0] dev;
    logic [22:0]        div;

    int n_run  = 0;
    int n_fail = 0;
    int m_act  = 0;   // 0 off, 1 down, 2 centred
    int m_ph   = 0;
    int prev_dev = 0;
    bit have_prev = 1'b0;

    always #2 clk = ~clk;

    ssc_profile_gen u_dut (
        .clk_i        (clk),
        .rst_n_i      (rst_n),
        .spread_sel_i (sel),
        .dev_o        (dev),
        .div_o        (div)
    );

    function automatic int req_of(input logic [1:0] s);
        if (s == 2'b00) return 1;
        if (s == 2'b11) return 0;
        return 2;
    endfunction

    function automatic int exp_dev(input int a, input int p);
        int m;
        int s;
        if (a == 1) begin
            m = (p < HALF) ? p : PER - p;
            return -((m * DPK) / HALF);
        end
        if (a == 2) begin
            if (p < Q)          s = p;
            else if (p < 3 * Q) s = HALF - p;
            else                s = p - PER;
            return (s * CPK) / Q;
        end
        return 0;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input logic [1:0] s, input string tag);
        int r;
        int e;
        int d;
        bit zero_pt;
        string t;
        sel = s;
        r = req_of(s);
        zero_pt = (m_act == 0) || (m_ph == 0) || (m_act == 2 && m_ph == HALF);
        if (zero_pt && r != m_act) begin
            m_act = r;
            m_ph  = 0;
        end else if (m_act == 0) begin
            m_ph = 0;
        end else begin
            m_ph = (m_ph + 1) % PER;
        end
        @(posedge clk);
        @(negedge clk);
        e = exp_dev(m_act, m_ph);
        d = int'(dev);
        if (tag != "")       t = tag;
        else if (m_act == 0) t = "R2";
        else if (m_act == 1) t = "R4";
        else                 t = "R5";
        chk(t, d, e);
        chk("R7 divide word", int'(div), NOMW + NOM * e);
        if (have_prev)
            chk("R9 step size", ((d - prev_dev) <= 1 && (prev_dev - d) <= 1) ? 1 : 0, 1);
        if (m_act == 1) chk("R10 down range", (d <= 0 && d >= -DPK) ? 1 : 0, 1);
        if (m_act == 2) chk("R10 centre range", (d <= CPK && d >= -CPK) ? 1 : 0, 1);
        prev_dev  = d;
        have_prev = 1'b1;
    endtask

    task automatic do_reset(input logic [1:0] s, input int n);
        rst_n = 1'b0;
        sel   = s;
        repeat (n) @(posedge clk);
        @(negedge clk);
        chk("R1 reset deviation", int'(dev), 0);
        chk("R1 reset divide", int'(div), NOMW);
        m_act = 0;
        m_ph  = 0;
        have_prev = 1'b0;
        rst_n = 1'b1;
    endtask

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int saved;
        rst_n = 1'b0;
        sel   = 2'b11;
        @(negedge clk);
        do_reset(2'b11, 3);
        for (int i = 0; i < 30; i++) step(2'b11, "R2");
        // down-spread over more than one period
        for (int i = 0; i < 1000; i++) step(2'b00, "");
        // R8: request centred mid-ramp, must wait for phase 0
        for (int i = 0; i < 700; i++) step(2'b01, "R8");
        for (int i = 0; i < 300; i++) step(2'b01, "");
        // R8: request off mid-ramp in centred mode
        for (int i = 0; i < 400; i++) step(2'b11, "R8");
        // R3: code 10 gives the centred profile
        for (int i = 0; i < 900; i++) step(2'b10, "R3");
        // R8: request lands exactly on the centred mid-point
        while (m_ph != HALF) step(2'b10, "R3");
        for (int i = 0; i < 900; i++) step(2'b00, "R8");
        // R8: request lands exactly on the down-spread wrap
        while (m_ph != 0) step(2'b00, "");
        for (int i = 0; i < 20; i++) step(2'b11, "R8");
        // R6: profile repeats after one period
        for (int i = 0; i < 123; i++) step(2'b00, "");
        saved = int'(dev);
        for (int i = 0; i < PER; i++) step(2'b00, "R6");
        chk("R6 period repeat", int'(dev), saved);
        // R3 vs centred 01 phase check then reset mid-run
        for (int i = 0; i < 300; i++) step(2'b01, "");
        do_reset(2'b01, 2);
        for (int i = 0; i < 500; i++) step(2'b01, "");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule